// File: doc/BRIEF.md
# Interframe Spacing Countdown Timer

This block measures the quiet gap a serial controller leaves on the line between two transmitted frames. It serves both the carrier-sense and the bit-synchronous framing modes. Software writes an 8-bit spacing value in bit times. Only even spacings are possible, so the block keeps half of that value and loads it into a 7-bit down-counter. The baud generator supplies a one-cycle tick per bit time. On each tick the counter steps down by one. The half value is counted to zero twice in a row, and the two passes together make the full gap.

The current count and a pass indicator can be read back as one byte at any time. The transmitter watches the `spaceDone` output. It pulses `txStart` when a new transmission begins, and that pulse starts a fresh gap from the stored value. If the carrier reappears during a gap, the gap starts again from the stored value. This retrigger is suppressed when deterministic collision resolution is selected.

Top module: `ifs_timer`

## Requirements
- R1: After reset, `rdData` reads 0x00 and `spaceDone` is 1.
- R2: A write of value V sets `rdData` to {V[7:1], 1'b1} and clears `spaceDone` in the next cycle. Bit 0 of V is dropped.
- R3: The count changes only on a cycle with `bitTick` high, and then drops by exactly one. With no tick and no control strobe, `rdData` holds its value.
- R4: A gap of even value V lasts V ticks. After the first V/2 ticks, `rdData` reads {V[7:1], 1'b0}, meaning the count was reloaded for the second pass. `spaceDone` rises in the cycle after the last tick. An odd V behaves like V-1.
- R5: A written half value of 0 (V = 0 or V = 1) gives a 256-tick gap. The first tick after the load reads back 0xFF.
- R6: While `spaceDone` is high, `rdData` reads 0x00. Ticks and carrier pulses leave the block unchanged. Only a write or `txStart` clears `spaceDone`.
- R7: A `txStart` pulse restarts the gap from the stored half value in the first pass ({half, 1}) and clears `spaceDone`.
- R8: A `carrierBack` pulse during a gap, in either pass, restarts the count at the stored half value in the first pass, provided `detMode` is 0.
- R9: With `detMode` at 1, `carrierBack` has no effect on the count or the pass bit.
- R10: A `carrierBack` pulse while `spaceDone` is high is ignored.
- R11: A write during a running gap replaces the stored value and restarts at the first pass at once.
- R12: A write in the same cycle as `txStart`, `carrierBack` and `bitTick` wins. The readback is then {V[7:1], 1} with no tick applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the spacing value |
| wrData | input | 8 | Spacing value in bit times |
| bitTick | input | 1 | One-cycle pulse per bit time |
| txStart | input | 1 | Transmitter pulse at the start of a transmission |
| carrierBack | input | 1 | Pulse when the carrier reappears on the line |
| detMode | input | 1 | Deterministic collision resolution selected; disables retrigger |
| rdData | output | 8 | {count[6:0], first-pass flag} |
| spaceDone | output | 1 | Gap complete; transmitter may send |

## Verification
The hardest states to reach are a retrigger in the second pass and the 256-tick wrap of a zero load. Both require a long run of ticks at a known point before the pulse of interest. The bench counts ticks from each write and checks the readback at the exact tick where the pass changes. It fires `carrierBack` only after crossing into the second pass. It also drives a zero and a one value through all 256 ticks.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef struct packed {
    logic storeVal;   // capture a newly written half value
    logic loadCount;  // load the counter (new value or stored value)
    logic decCount;   // step the counter down by one
  } ifsStrobes_t;
endpackage

// File: rtl/ifs_datapath.sv
module ifs_datapath
  import ifs_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ifsStrobes_t      strobes,
  input  logic [CNT_W:0]   wrData,
  output logic [CNT_W-1:0] count,
  output logic             countIsOne
);
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] wrHalf;

  assign wrHalf     = wrData[CNT_W:1];
  assign countIsOne = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      count     <= '0;
    end else begin
      if (strobes.storeVal) reloadVal <= wrHalf;
      if (strobes.loadCount) count <= strobes.storeVal ? wrHalf : reloadVal;
      else if (strobes.decCount) count <= count - CNT_W'(1);
    end
  end

  // R4/R8: a reload that does not come from a write restores the stored value
  assert_reload_stored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCount && !strobes.storeVal) |=> (count == $past(reloadVal)));

  // R3: a decrement lowers the count by exactly one
  assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decCount && !strobes.loadCount) |=> (count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/ifs_control.sv
module ifs_control
  import ifs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        txStart,
  input  logic        carrierBack,
  input  logic        detMode,
  input  logic        bitTick,
  input  logic        countIsOne,
  output ifsStrobes_t strobes,
  output logic        phase,
  output logic        running
);
  logic retrig;
  logic startPass;
  logic stepOk;
  logic lastStep;

  always_comb begin
    retrig    = carrierBack && running && !detMode;
    startPass = wrEn || txStart || retrig;
    stepOk    = bitTick && running && !startPass;
    lastStep  = stepOk && countIsOne;
    strobes.storeVal  = wrEn;
    strobes.loadCount = startPass || (lastStep && phase);
    strobes.decCount  = stepOk && !(countIsOne && phase);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      running <= 1'b0;
    end else if (startPass) begin
      phase   <= 1'b1;
      running <= 1'b1;
    end else if (lastStep) begin
      if (phase) phase <= 1'b0;
      else running <= 1'b0;
    end
  end

  // R6: an idle timer stays idle unless written or started
  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !wrEn && !txStart) |=> !running);

  // R4: the second pass never returns to the first without a restart
  assert_no_phase_back_R4: assert property (@(posedge clk) disable iff (!rstN)
    (running && !phase && !wrEn && !txStart && !carrierBack) |=> !phase);
endmodule

// File: rtl/ifs_timer.sv
module ifs_timer
  import ifs_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CNT_W:0]   wrData,
  input  logic             bitTick,
  input  logic             txStart,
  input  logic             carrierBack,
  input  logic             detMode,
  output logic [CNT_W:0]   rdData,
  output logic             spaceDone
);
  localparam int VAL_W = CNT_W + 1;

  ifsStrobes_t      strobes;
  logic [CNT_W-1:0] count;
  logic             countIsOne;
  logic             phase;
  logic             running;

  ifs_control u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .txStart(txStart),
    .carrierBack(carrierBack), .detMode(detMode), .bitTick(bitTick),
    .countIsOne(countIsOne), .strobes(strobes), .phase(phase), .running(running)
  );

  ifs_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .count(count), .countIsOne(countIsOne)
  );

  assign rdData    = VAL_W'({count, phase});
  assign spaceDone = !running;

  // R2: a write shows its half value in the first pass next cycle
  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == {$past(wrData[CNT_W:1]), 1'b1}) && !spaceDone);

  // R6: the done state reads back as zero
  assert_done_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    spaceDone |-> (rdData == '0));

  // R9: deterministic mode blocks the carrier retrigger
  assert_det_no_retrig_R9: assert property (@(posedge clk) disable iff (!rstN)
    (detMode && carrierBack && !wrEn && !txStart && !bitTick) |=> $stable(rdData));

  // R3: without ticks or strobes the readback holds
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!bitTick && !wrEn && !txStart && !carrierBack) |=> $stable(rdData));
endmodule

// File: tb/sim_ifs_timer.sv
module sim_ifs_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       bitTick = 1'b0;
  logic       txStart = 1'b0;
  logic       carrierBack = 1'b0;
  logic       detMode = 1'b0;
  logic [7:0] rdData;
  logic       spaceDone;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  // {written value, expected gap length in ticks}
  localparam logic [7:0] VAL [6] = '{8'd10, 8'd2, 8'd7, 8'd255, 8'd0, 8'd1};
  localparam int         EXP [6] = '{10, 2, 6, 254, 256, 256};

  ifs_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .bitTick(bitTick),
    .txStart(txStart), .carrierBack(carrierBack), .detMode(detMode),
    .rdData(rdData), .spaceDone(spaceDone)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual cycles %0d expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    compared = compared + 1;
    if (actual != expected) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  // drive for one cycle starting at a negedge, return at the following negedge
  task automatic pulse(input logic w, input logic [7:0] d, input logic t,
                       input logic c, input logic b);
    wrEn = w; wrData = d; txStart = t; carrierBack = c; bitTick = b;
    @(negedge clk);
    wrEn = 1'b0; txStart = 1'b0; carrierBack = 1'b0; bitTick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset rdData", rdData, 8'h00);
    check("R1 reset spaceDone", spaceDone, 1);

    // table walk: full gaps, pass boundary, zero wrap
    for (int v = 0; v < 6; v++) begin
      int n;
      int halfTicks;
      n = 0;
      halfTicks = (VAL[v][7:1] == 0) ? 128 : int'(VAL[v][7:1]);
      pulse(1'b1, VAL[v], 1'b0, 1'b0, 1'b0);
      check("R2 write readback", rdData, {VAL[v][7:1], 1'b1});
      while (!spaceDone && n < 400) begin
        ticks(1);
        n++;
        if (n == 1 && VAL[v][7:1] == 0) check("R5 first tick wraps", rdData, 8'hFF);
        if (n == halfTicks) check("R4 second pass reload", rdData, {VAL[v][7:1], 1'b0});
      end
      check("R4 R5 gap length", n, EXP[v]);
      check("R6 done readback", rdData, 8'h00);
    end

    // done state ignores ticks and carrier
    ticks(3);
    check("R6 ticks ignored when done", {7'd0, spaceDone, rdData}, 16'h0100);
    pulse(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R10 carrier ignored when done", {7'd0, spaceDone, rdData}, 16'h0100);

    // write, hold, tick
    pulse(1'b1, 8'h0B, 1'b0, 1'b0, 1'b0);
    check("R2 odd bit dropped", rdData, 8'h0B);
    repeat (3) @(negedge clk);
    check("R3 hold without tick", rdData, 8'h0B);
    ticks(1);
    check("R3 one tick", rdData, 8'h09);

    // rewrite mid-gap
    pulse(1'b1, 8'h20, 1'b0, 1'b0, 1'b0);
    check("R11 rewrite restarts", rdData, 8'h21);

    // retrigger in first pass
    ticks(3);
    check("R3 three ticks", rdData, 8'h1B);
    pulse(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R8 retrigger pass one", rdData, 8'h21);

    // retrigger in second pass
    ticks(18);
    check("R4 into second pass", rdData, 8'h1C);
    pulse(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R8 retrigger pass two", rdData, 8'h21);

    // deterministic mode blocks retrigger
    ticks(1);
    detMode = 1'b1;
    pulse(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    check("R9 retrigger suppressed", rdData, 8'h1F);
    detMode = 1'b0;

    // finish the gap, then start from the stored value
    ticks(31);
    check("R4 gap finished", spaceDone, 1);
    pulse(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    check("R7 txStart reload", rdData, 8'h21);
    check("R7 txStart clears done", spaceDone, 0);

    // write wins over every other strobe in the same cycle
    pulse(1'b1, 8'h06, 1'b1, 1'b1, 1'b1);
    check("R12 write priority", rdData, 8'h07);
    ticks(6);
    check("R12 new value governs gap", spaceDone, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule